// File: doc/BRIEF.md
# Phase Resynchronization Supervisor

This block decides when the second stage of a two-channel switching controller must realign its phase to the first channel. For every second-stage switching period it receives a strobe and a verdict: the output was identified properly or improperly. From these it keeps an error score that climbs slowly on bad periods and falls twice as fast on good ones. Separately, it counts channel-1 switching periods since the last realignment. It raises a one-cycle resync pulse once the score is above a programmable trip level and enough channel-1 periods have gone by since the previous pulse.

Both limits come from one 8-bit configuration word. The hold-off count sits in the upper nibble and the trip level in the lower nibble. An enable input switches the mechanism on. A bypass input marks the case where an external sync source drives the phase directly. In that case the supervisor stays silent.

Top module: `phase_resync_supervisor`

## Requirements
- R1: While reset is asserted the pulse is low. After reset the error score is 0 and the period gap is saturated at 15, so the hold-off is already met and the first resync is not delayed.
- R2: A strobe with an improper verdict (id_strobe=1, id_proper=0) raises the error score by 1. The score saturates at 31 and never wraps.
- R3: A strobe with a proper verdict (id_strobe=1, id_proper=1) lowers the error score by 2. The score floors at 0.
- R4: A resync needs an updated error score strictly greater than the trip level, cfg_word[3:0] (0 to 15). A score equal to the trip level does not fire.
- R5: A resync needs an updated period gap of at least the hold-off, cfg_word[7:4] (0 to 15). The gap counts ch1_strobe pulses since the last resync and saturates at 15.
- R6: resync_pulse is registered. It is high for the one cycle after the clock edge that sampled the triggering inputs. That edge also clears both the error score and the period gap to 0.
- R7: While resync_en is 0 no pulse is issued. The error score is held at 0 and the period gap at 15.
- R8: While ext_bypass is 1 no pulse is issued. The error score is held at 0 and the period gap at 15.
- R9: When id_strobe and ch1_strobe are high in the same cycle, both counters update. The resync decision uses both updated values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 8 | [7:4] hold-off in channel-1 periods, [3:0] trip level |
| resync_en | input | 1 | Mechanism enable |
| ext_bypass | input | 1 | Phase driven externally; suppresses resync |
| id_strobe | input | 1 | One-cycle marker of a second-stage period verdict |
| id_proper | input | 1 | Verdict: 1 proper, 0 improper (valid with id_strobe) |
| ch1_strobe | input | 1 | One-cycle marker of a channel-1 switching period |
| resync_pulse | output | 1 | One-cycle resync request |

## Verification
The only port that shows internal state is the pulse. A wrong internal value therefore shows up as a pulse that comes too early, too late or not at all.

- **Error score:** a score that wraps instead of saturating, or fails to floor, moves the firing point by several strobes. The bench drives long runs to expose this. One run is 40 improper periods followed by proper periods. Another drives proper periods from zero.
- **Period gap:** a gap that wraps or is not preset shows within one strobe once the trip level is already exceeded.
- **Hold-off and trip level:** an off-by-one comparison shows in the very cycle where the score equals the trip level or the gap equals the hold-off.

// File: rtl/phase_resync_pkg.sv
// Shared types and sizes for the phase resynchronization supervisor.
// Assumes the configuration word holds two equal-width unsigned fields.
package phase_resync_pkg;

    localparam int FIELD_W = 4;
    localparam int CFG_W   = 2 * FIELD_W;

    // Upper field is the hold-off, lower field the trip level.
    typedef struct packed {
        logic [FIELD_W-1:0] hold_off;
        logic [FIELD_W-1:0] trip_level;
    } resync_cfg_t;

endpackage

// File: rtl/prs_score_unit.sv
// Error score keeper: asymmetric saturating up/down counter.
// Assumes id_proper is only meaningful while id_strobe is high.
// Presents the next value combinationally so the decision uses it.
module prs_score_unit #(
    parameter int SCORE_W   = 5,
    parameter int UP_STEP   = 1,
    parameter int DOWN_STEP = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               id_strobe,
    input  logic               id_proper,
    output logic [SCORE_W-1:0] score_next,
    output logic [SCORE_W-1:0] score_q
);

    localparam logic [SCORE_W-1:0] MAX_SCORE = {SCORE_W{1'b1}};
    localparam logic [SCORE_W-1:0] UP_V      = SCORE_W'(UP_STEP);
    localparam logic [SCORE_W-1:0] DOWN_V    = SCORE_W'(DOWN_STEP);

    // Compute the saturated next score from the current verdict.
    always_comb begin
        score_next = score_q;
        if (id_strobe) begin
            if (id_proper) begin
                score_next = (score_q >= DOWN_V) ? score_q - DOWN_V : '0;
            end else begin
                score_next = (score_q > MAX_SCORE - UP_V) ? MAX_SCORE : score_q + UP_V;
            end
        end
    end

    // Hold the score; clear on reset, on resync or while inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            score_q <= '0;
        end else if (clear) begin
            score_q <= '0;
        end else begin
            score_q <= score_next;
        end
    end

endmodule

// File: rtl/prs_gap_unit.sv
// Channel-1 period gap counter since the last resync, saturating at its
// maximum. It is preset to the maximum on reset and while inactive, so a
// pending hold-off never delays the first resync.
module prs_gap_unit #(
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preset,
    input  logic             clear,
    input  logic             ch1_strobe,
    output logic [GAP_W-1:0] gap_next,
    output logic [GAP_W-1:0] gap_q
);

    localparam logic [GAP_W-1:0] MAX_GAP = {GAP_W{1'b1}};

    // Advance on each channel-1 period until saturated.
    always_comb begin
        gap_next = gap_q;
        if (ch1_strobe && (gap_q != MAX_GAP)) begin
            gap_next = gap_q + GAP_W'(1);
        end
    end

    // Hold the gap; preset wins over clear, clear over counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= MAX_GAP;
        end else if (preset) begin
            gap_q <= MAX_GAP;
        end else if (clear) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_next;
        end
    end

endmodule

// File: rtl/prs_decide.sv
// Resync decision: compares the updated score and gap with the configured
// limits and registers a one-cycle pulse. Assumes SCORE_W >= FIELD_W and
// GAP_W >= FIELD_W so zero extension keeps the comparisons exact.
module prs_decide
    import phase_resync_pkg::*;
#(
    parameter int SCORE_W = 5,
    parameter int GAP_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  resync_cfg_t        cfg,
    input  logic [SCORE_W-1:0] score_next,
    input  logic [GAP_W-1:0]   gap_next,
    output logic               fire,
    output logic               pulse_q
);

    localparam int CMP_W = (SCORE_W > GAP_W) ? SCORE_W : GAP_W;

    logic [CMP_W-1:0] score_x;
    logic [CMP_W-1:0] gap_x;
    logic [CMP_W-1:0] trip_x;
    logic [CMP_W-1:0] hold_x;

    // Widen all operands to a common compare width.
    always_comb begin
        score_x = CMP_W'(score_next);
        gap_x   = CMP_W'(gap_next);
        trip_x  = CMP_W'(cfg.trip_level);
        hold_x  = CMP_W'(cfg.hold_off);
    end

    // Fire when active, score above trip level and hold-off met.
    always_comb begin
        fire = active && (score_x > trip_x) && (gap_x >= hold_x);
    end

    // Register the request as a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= fire;
        end
    end

endmodule

// File: rtl/phase_resync_supervisor.sv
// Top of the phase resynchronization supervisor. It combines the score
// keeper, the period gap counter and the decision stage. Assumes strobes
// are single-cycle and synchronous to clk.
module phase_resync_supervisor
    import phase_resync_pkg::*;
#(
    parameter int SCORE_W = 5,
    parameter int GAP_W   = FIELD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             resync_en,
    input  logic             ext_bypass,
    input  logic             id_strobe,
    input  logic             id_proper,
    input  logic             ch1_strobe,
    output logic             resync_pulse
);

    resync_cfg_t        cfg;
    logic               active;
    logic               fire;
    logic               clear_cnt;
    logic [SCORE_W-1:0] score_next;
    logic [SCORE_W-1:0] score_q;
    logic [GAP_W-1:0]   gap_next;
    logic [GAP_W-1:0]   gap_q;

    // Split the word into its fields and qualify the mechanism.
    always_comb begin
        cfg       = resync_cfg_t'(cfg_word);
        active    = resync_en && !ext_bypass;
        clear_cnt = fire || !active;
    end

    prs_score_unit #(
        .SCORE_W   (SCORE_W),
        .UP_STEP   (1),
        .DOWN_STEP (2)
    ) u_score (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear_cnt),
        .id_strobe  (id_strobe),
        .id_proper  (id_proper),
        .score_next (score_next),
        .score_q    (score_q)
    );

    prs_gap_unit #(
        .GAP_W (GAP_W)
    ) u_gap (
        .clk        (clk),
        .rst_n      (rst_n),
        .preset     (!active),
        .clear      (fire),
        .ch1_strobe (ch1_strobe),
        .gap_next   (gap_next),
        .gap_q      (gap_q)
    );

    prs_decide #(
        .SCORE_W (SCORE_W),
        .GAP_W   (GAP_W)
    ) u_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .cfg        (cfg),
        .score_next (score_next),
        .gap_next   (gap_next),
        .fire       (fire),
        .pulse_q    (resync_pulse)
    );

endmodule

// File: rtl/prs_checker.sv
// Property checker for the supervisor; observes ports and the two counters.
// Bound to every instance of the top module below.
module prs_checker #(
    parameter int SCORE_W = 5,
    parameter int GAP_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [7:0]         cfg_word,
    input logic               resync_en,
    input logic               ext_bypass,
    input logic               id_strobe,
    input logic               id_proper,
    input logic               ch1_strobe,
    input logic               resync_pulse,
    input logic [SCORE_W-1:0] score,
    input logic [GAP_W-1:0]   gap
);

    localparam logic [SCORE_W-1:0] SMAX = {SCORE_W{1'b1}};
    localparam logic [GAP_W-1:0]   GMAX = {GAP_W{1'b1}};

    logic live;
    assign live = resync_en && !ext_bypass;

    p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (live && id_strobe && !id_proper && score != SMAX)
        |=> (resync_pulse || score == $past(score) + SCORE_W'(1)));

    p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (live && id_strobe && id_proper && score >= SCORE_W'(2))
        |=> (resync_pulse || score == $past(score) - SCORE_W'(2)));

    p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (live && id_strobe && id_proper && score < SCORE_W'(2)) |=> score == '0);

    p_trip_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (SCORE_W'(cfg_word[3:0]) >= score && !(id_strobe && !id_proper)) |=> !resync_pulse);

    p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (GAP_W'(cfg_word[7:4]) > gap && !ch1_strobe) |=> !resync_pulse);

    p_gap_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (live && gap == GMAX) |=> (resync_pulse || gap == GMAX));

    p_pulse_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resync_pulse |-> (score == '0 && gap == '0));

    p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !resync_en |=> (!resync_pulse && score == '0 && gap == GMAX));

    p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_bypass |=> (!resync_pulse && score == '0 && gap == GMAX));

endmodule

bind phase_resync_supervisor prs_checker #(
    .SCORE_W (SCORE_W),
    .GAP_W   (GAP_W)
) u_prs_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_word     (cfg_word),
    .resync_en    (resync_en),
    .ext_bypass   (ext_bypass),
    .id_strobe    (id_strobe),
    .id_proper    (id_proper),
    .ch1_strobe   (ch1_strobe),
    .resync_pulse (resync_pulse),
    .score        (score_q),
    .gap          (gap_q)
);

// File: tb/test_phase_resync_supervisor.sv
`timescale 1ns/1ps
module test_phase_resync_supervisor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_word = 8'h00;
    logic       resync_en = 1'b0;
    logic       ext_bypass = 1'b0;
    logic       id_strobe = 1'b0;
    logic       id_proper = 1'b0;
    logic       ch1_strobe = 1'b0;
    logic       resync_pulse;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    phase_resync_supervisor i_phase_resync_supervisor (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_word     (cfg_word),
        .resync_en    (resync_en),
        .ext_bypass   (ext_bypass),
        .id_strobe    (id_strobe),
        .id_proper    (id_proper),
        .ch1_strobe   (ch1_strobe),
        .resync_pulse (resync_pulse)
    );

    // Vector bits: {expected pulse, id_strobe, id_proper, ch1_strobe}
    localparam logic [3:0] IDL = 4'b0000;
    localparam logic [3:0] BAD = 4'b0100;
    localparam logic [3:0] GUD = 4'b0110;
    localparam logic [3:0] CH  = 4'b0001;
    localparam logic [3:0] BCH = 4'b0101;
    localparam logic [3:0] HIT = 4'b1000;
    localparam int NVEC = 30;
    // cfg 8'h23: hold-off 2, trip level 3
    localparam logic [3:0] VEC [NVEC] = '{
        BAD, BAD, BAD, GUD, BAD, BAD, BAD|HIT,       // R2 R3 R4, fire at 4
        IDL,                                           // R6 single cycle
        BAD, BAD, BAD, BAD, BAD, CH, CH|HIT,           // R5 hold-off wait
        IDL,
        BAD, BAD, BAD, CH, BCH|HIT,                    // R9 joint update
        IDL,
        GUD, GUD, CH, CH, BAD, BAD, BAD, BAD|HIT       // R3 floor at 0
    };

    task automatic check(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: resync_pulse=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic v, input logic g, input logic c,
                        input logic exp, input string req);
        @(negedge clk);
        id_strobe  = v;
        id_proper  = g;
        ch1_strobe = c;
        @(posedge clk);
        #2;
        check(resync_pulse, exp, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        id_strobe = 1'b0; id_proper = 1'b0; ch1_strobe = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        check(resync_pulse, 1'b0, "R1 pulse low in reset");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // Table walk
        cfg_word = 8'h23; resync_en = 1'b1; ext_bypass = 1'b0;
        do_reset();
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][2], VEC[i][1], VEC[i][0], VEC[i][3], "table R2/R3/R4/R5/R6/R9");
        end

        // R1: gap saturated after reset, hold-off 15 already met
        cfg_word = 8'hF0;
        do_reset();
        step(1, 0, 0, 1'b1, "R1 first resync not delayed");
        step(0, 0, 0, 1'b0, "R6 pulse drops");

        // R4: trip level 15, equality does not fire
        cfg_word = 8'hFF;
        do_reset();
        for (int i = 0; i < 15; i++) step(1, 0, 0, 1'b0, "R4 score at or below trip");
        step(1, 0, 0, 1'b1, "R4 score 16 above trip 15");

        // R2: saturate at 31 while hold-off blocks, then drain to 17
        for (int i = 0; i < 40; i++) step(1, 0, 0, 1'b0, "R5 hold-off blocks");
        for (int i = 0; i < 7; i++) step(1, 1, 0, 1'b0, "R3 drain");
        for (int i = 0; i < 14; i++) step(0, 0, 1, 1'b0, "R5 gap below 15");
        step(0, 0, 1, 1'b1, "R2 saturated score 17 fires on gap 15");

        // R5: gap saturates at 15 over 20 periods
        for (int i = 0; i < 20; i++) step(0, 0, 1, 1'b0, "R5 score zero");
        cfg_word = 8'hF0;
        step(1, 0, 0, 1'b1, "R5 gap saturated at 15");

        // R7: disable clears score and presets gap
        cfg_word = 8'h00;
        do_reset();
        step(1, 0, 0, 1'b1, "R7 setup fire");
        resync_en = 1'b0;
        for (int i = 0; i < 5; i++) step(1, 0, 0, 1'b0, "R7 no pulse while disabled");
        resync_en = 1'b1;
        cfg_word = 8'hF3;
        step(1, 1, 0, 1'b0, "R7 score held at 0");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 1'b0, "R7 counting from 0");
        step(1, 0, 0, 1'b1, "R7 gap preset to 15");

        // R8: bypass silences and clears
        cfg_word = 8'h00;
        ext_bypass = 1'b1;
        for (int i = 0; i < 3; i++) step(1, 0, 0, 1'b0, "R8 no pulse in bypass");
        ext_bypass = 1'b0;
        step(1, 1, 0, 1'b0, "R8 score cleared during bypass");
        step(1, 0, 0, 1'b1, "R8 resumes after bypass");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule